// File: doc/BRIEF.md
# Multi-Ratio Clock Divider with Coincidence Sync

This block turns one fast source clock into a family of related output waveforms. Every output is a registered flip-flop that changes only on an internal advance pulse called the tick. Banks A, B and C run at small integer frequency ratios to each other, including the non-binary pairs 3:2 and 4:3. Banks A and C share one common phase origin, so their rising edges meet at fixed points. A sync output rises during the tick slot that comes just before each point where A and C rise together. A fourth bank carries either that sync signal or a copy of bank C. A feedback output has its own divide select, independent of the banks.

The tick normally fires on every source cycle, or on every second cycle when the prescale bit of the select code is set. In bypass mode the tick fires only on each rising edge of a slow test clock, after a two-stage synchronizer, so the dividers can be single-stepped. Because the dividers stay in the path, a bank needs several test-clock edges per output edge. The select codes are meant to be static. After a code change, the master reset must be applied to bring the banks back into phase. The same reset is used at power-up.

Top module: `ratio_clock_divider`

## Requirements
- R1: While `rst` is high, all six outputs are low. The first tick after reset drives `bank_a`, `bank_b`, `bank_c` and `fb_out` high together.
- R2: `freq_sel[2:0]` sets the relative frequencies (A,B,C). The codes are 0:(1,1,1), 1:(2,2,1), 2:(3,3,1), 3:(3,3,2), 4:(4,4,1), 5:(4,4,3), 6:(4,3,1) and 7:(4,3,2). A bank at relative frequency f has a period of 24/f ticks.
- R3: With `freq_sel[3]`=1, a tick fires on every second source cycle instead of every cycle. This halves all output frequencies. Two ticks never come on consecutive cycles.
- R4: `sync_out` is high for exactly one tick slot, the slot just before each tick at which A and C rise together. The first rise after reset is not flagged. Over 48 ticks it pulses 48/lcm(period A, period C) times.
- R5: With `bank_d_sel`=1, `bank_d` equals `sync_out`. With `bank_d_sel`=0, `bank_d` equals `bank_c`.
- R6: `fb_sel` sets the period of `fb_out` in ticks. The codes are 0:24, 1:12, 2:8, 3:6, 4:48 and 5:4. The unused codes 6 and 7 fall back to 24.
- R7: With `bypass_en`=1, a tick fires only once per rising edge of `test_clk`. With no test-clock edge, every output holds its value.
- R8: Every bank spends exactly half of each of its periods high. It is high in the first half of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high master reset |
| test_clk | input | 1 | Slow stepping clock used in bypass mode |
| bypass_en | input | 1 | 1: tick on test_clk rising edges |
| freq_sel | input | 4 | Bit 3 prescale by two, bits 2:0 ratio code |
| fb_sel | input | 3 | Feedback period code |
| bank_d_sel | input | 1 | 1: bank D carries sync, 0: copy of bank C |
| bank_a | output | 1 | Bank A waveform |
| bank_b | output | 1 | Bank B waveform |
| bank_c | output | 1 | Bank C waveform |
| bank_d | output | 1 | Bank D waveform (sync or copy of C) |
| sync_out | output | 1 | Coincidence marker ahead of shared A/C rises |
| fb_out | output | 1 | Feedback waveform |

## Verification
The bench counts rising edges and sync pulses over exactly 48 ticks for every ratio code and for several prescaled codes. A design with a wrong period or a mis-decoded ratio code would show the wrong count on one bank. In 3:2 and 4:3 it checks that every shared A/C rise, except the one after reset, follows a high sync sample. A sync placed on the rise itself, or one slot too early, fails this check. It steps the dividers with 48 test-clock edges and idles with no edges. A bypass path that counted levels instead of edges, or one that leaked source-clock ticks, would change the counts or move an output during the idle time. The two unused feedback codes are run to show that they fall back to a period of 24.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // One base frequency unit spans this many ticks; relative frequencies 1..4 divide it evenly
    localparam int UNIT_TICKS = 24;
    localparam int CNT_W      = 6;
    localparam int RATIO_W    = 3;
    localparam int FBSEL_W    = 3;
    localparam int NUM_DIV    = 4;

    localparam int IDX_A  = 0;
    localparam int IDX_B  = 1;
    localparam int IDX_C  = 2;
    localparam int IDX_FB = 3;

    typedef logic [CNT_W-1:0] period_t;

    typedef enum logic [RATIO_W-1:0] {
        RATIO_1_1   = 3'd0,
        RATIO_2_1   = 3'd1,
        RATIO_3_1   = 3'd2,
        RATIO_3_2   = 3'd3,
        RATIO_4_1   = 3'd4,
        RATIO_4_3   = 3'd5,
        RATIO_4_3_1 = 3'd6,
        RATIO_4_3_2 = 3'd7
    } ratio_e;

    typedef struct packed {
        period_t a;
        period_t b;
        period_t c;
    } bank_periods_t;

    function automatic period_t period_of(input int rel_freq);
        return period_t'(UNIT_TICKS / rel_freq);
    endfunction

    function automatic bank_periods_t make_periods(input int fa, input int fb, input int fc);
        bank_periods_t p;
        p.a = period_of(fa);
        p.b = period_of(fb);
        p.c = period_of(fc);
        return p;
    endfunction

    function automatic bank_periods_t decode_ratio(input logic [RATIO_W-1:0] code);
        case (ratio_e'(code))
            RATIO_1_1:   return make_periods(1, 1, 1);
            RATIO_2_1:   return make_periods(2, 2, 1);
            RATIO_3_1:   return make_periods(3, 3, 1);
            RATIO_3_2:   return make_periods(3, 3, 2);
            RATIO_4_1:   return make_periods(4, 4, 1);
            RATIO_4_3:   return make_periods(4, 4, 3);
            RATIO_4_3_1: return make_periods(4, 3, 1);
            RATIO_4_3_2: return make_periods(4, 3, 2);
            default:     return make_periods(1, 1, 1);
        endcase
    endfunction

    function automatic period_t decode_fb(input logic [FBSEL_W-1:0] code);
        case (code)
            3'd0:    return period_t'(UNIT_TICKS);
            3'd1:    return period_t'(UNIT_TICKS / 2);
            3'd2:    return period_t'(UNIT_TICKS / 3);
            3'd3:    return period_t'(UNIT_TICKS / 4);
            3'd4:    return period_t'(UNIT_TICKS * 2);
            3'd5:    return period_t'(UNIT_TICKS / 6);
            default: return period_t'(UNIT_TICKS);
        endcase
    endfunction

endpackage

// File: rtl/tick_source.sv
module tick_source (
    input  logic clk,
    input  logic rst,
    input  logic test_clk,
    input  logic bypass_en,
    input  logic prescale_en,
    output logic tick
);
    logic tc_meta, tc_sync, tc_prev;
    logic half_q;
    logic raw_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_meta <= 1'b0;
            tc_sync <= 1'b0;
            tc_prev <= 1'b0;
        end else begin
            tc_meta <= test_clk;
            tc_sync <= tc_meta;
            tc_prev <= tc_sync;
        end
    end

    assign raw_tick = bypass_en ? (tc_sync & ~tc_prev) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst)           half_q <= 1'b0;
        else if (raw_tick) half_q <= ~half_q;
    end

    assign tick = raw_tick & (~prescale_en | half_q);

    // R3: a prescaled tick never repeats on the next cycle
    assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && prescale_en) |=> (!tick || !prescale_en));

    // R7: in bypass, ticks come from isolated test-clock edges, never back to back
    assert_bypass_single_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && bypass_en) |=> (!tick || !bypass_en));

endmodule

// File: rtl/bank_divider.sv
module bank_divider
    import clkdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  period_t period,
    output logic    level,
    output logic    slot_level,
    output logic    slot_last
);
    period_t cnt;
    period_t half;

    assign half       = period >> 1;
    assign slot_level = (cnt < half);
    assign slot_last  = (cnt == period - period_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (tick) begin
            level <= slot_level;
            cnt   <= slot_last ? '0 : cnt + period_t'(1);
        end
    end

    // R2: the phase counter stays inside the selected period
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < period);

    // R7: without a tick the bank output holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(level));

    // R8: a rise happens only when the slot at the start of a period is emitted
    assert_rise_at_origin_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !level && slot_level) |-> (cnt == '0));

endmodule

// File: rtl/coincidence_sync.sv
module coincidence_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic a_last,
    input  logic c_last,
    input  logic c_slot_level,
    input  logic d_sel,
    output logic sync_q,
    output logic d_q
);
    logic shared_next;

    assign shared_next = a_last & c_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            d_q    <= 1'b0;
        end else if (tick) begin
            sync_q <= shared_next;
            d_q    <= d_sel ? shared_next : c_slot_level;
        end
    end

    // R4: sync never spans two consecutive ticks
    assert_sync_one_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (sync_q && tick) |=> !sync_q);

endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       test_clk,
    input  logic       bypass_en,
    input  logic [3:0] freq_sel,
    input  logic [2:0] fb_sel,
    input  logic       bank_d_sel,
    output logic       bank_a,
    output logic       bank_b,
    output logic       bank_c,
    output logic       bank_d,
    output logic       sync_out,
    output logic       fb_out
);
    logic          tick;
    bank_periods_t bank_per;
    period_t       per        [NUM_DIV];
    logic          lvl        [NUM_DIV];
    logic          slot_lvl   [NUM_DIV];
    logic          slot_last  [NUM_DIV];

    tick_source u_tick (
        .clk         (clk),
        .rst         (rst),
        .test_clk    (test_clk),
        .bypass_en   (bypass_en),
        .prescale_en (freq_sel[3]),
        .tick        (tick)
    );

    assign bank_per    = decode_ratio(freq_sel[RATIO_W-1:0]);
    assign per[IDX_A]  = bank_per.a;
    assign per[IDX_B]  = bank_per.b;
    assign per[IDX_C]  = bank_per.c;
    assign per[IDX_FB] = decode_fb(fb_sel);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        bank_divider u_div (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .period     (per[g]),
            .level      (lvl[g]),
            .slot_level (slot_lvl[g]),
            .slot_last  (slot_last[g])
        );
    end

    coincidence_sync u_sync (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .a_last       (slot_last[IDX_A]),
        .c_last       (slot_last[IDX_C]),
        .c_slot_level (slot_lvl[IDX_C]),
        .d_sel        (bank_d_sel),
        .sync_q       (sync_out),
        .d_q          (bank_d)
    );

    assign bank_a = lvl[IDX_A];
    assign bank_b = lvl[IDX_B];
    assign bank_c = lvl[IDX_C];
    assign fb_out = lvl[IDX_FB];

    // R1: the first tick after reset raises A and C together
    assert_first_rise_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && tick) |=> (bank_a && bank_c));

    // R4: a sync slot is followed, at the next tick, by A and C both high
    assert_sync_precedes_R4: assert property (@(posedge clk) disable iff (rst)
        (sync_out && tick) |=> (bank_a && bank_c));

    // R5: with the copy selection held, bank D tracks bank C after a tick
    assert_d_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (!bank_d_sel && $past(!bank_d_sel) && $past(tick)) |-> (bank_d == bank_c));

endmodule

// File: tb/ratio_clock_divider_tb.sv
module ratio_clock_divider_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_clk = 1'b0;
    logic       bypass_en = 1'b0;
    logic [3:0] freq_sel = 4'd0;
    logic [2:0] fb_sel = 3'd0;
    logic       bank_d_sel = 1'b0;
    logic       bank_a, bank_b, bank_c, bank_d, sync_out, fb_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ratio_clock_divider u_dut (
        .clk(clk), .rst(rst), .test_clk(test_clk), .bypass_en(bypass_en),
        .freq_sel(freq_sel), .fb_sel(fb_sel), .bank_d_sel(bank_d_sel),
        .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c), .bank_d(bank_d),
        .sync_out(sync_out), .fb_out(fb_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rel_a(input int r);
        int t[8] = '{1, 2, 3, 3, 4, 4, 4, 4};
        return t[r];
    endfunction
    function automatic int rel_b(input int r);
        int t[8] = '{1, 2, 3, 3, 4, 4, 3, 3};
        return t[r];
    endfunction
    function automatic int rel_c(input int r);
        int t[8] = '{1, 1, 1, 2, 1, 3, 1, 2};
        return t[r];
    endfunction
    function automatic int fb_period(input int s);
        int t[8] = '{24, 12, 8, 6, 48, 4, 24, 24};
        return t[s];
    endfunction
    function automatic int gcd(input int x, input int y);
        int p = x;
        int q = y;
        while (q != 0) begin
            int r = p % q;
            p = q;
            q = r;
        end
        return p;
    endfunction

    task automatic do_reset(input bit byp, input int code, input int fbs, input bit dsel);
        @(negedge clk);
        rst = 1'b1;
        bypass_en = byp;
        freq_sel = 4'(code);
        fb_sel = 3'(fbs);
        bank_d_sel = dsel;
        test_clk = 1'b0;
        repeat (4) @(negedge clk);
        check({bank_a, bank_b, bank_c, bank_d, sync_out, fb_out} == 6'b0, "R1",
              "outputs during reset",
              int'({bank_a, bank_b, bank_c, bank_d, sync_out, fb_out}), 0);
        rst = 1'b0;
    endtask

    // Counts edges over exactly 48 ticks in normal or prescaled mode (R2, R3, R4, R5, R6, R8)
    task automatic run_ratio(input int code, input int fbs, input bit dsel);
        int r   = code % 8;
        int pre = (code >= 8) ? 2 : 1;
        int pa  = 24 / rel_a(r);
        int pc  = 24 / rel_c(r);
        int exp_sync = 48 / ((pa * pc) / gcd(pa, pc));
        int ra = 0, rb = 0, rc = 0, rd = 0, rs = 0, rf = 0, high_a = 0, bad_prec = 0;
        bit pa_ = 0, pb_ = 0, pc_ = 0, pd_ = 0, ps_ = 0, pf_ = 0, seen_first = 0;
        string tag = (pre == 2) ? "R3" : "R2";
        do_reset(1'b0, code, fbs, dsel);
        for (int i = 0; i < 48 * pre; i++) begin
            @(negedge clk);
            if (i == pre - 1)
                check(bank_a && bank_b && bank_c && fb_out, "R1", "first tick all high",
                      int'({bank_a, bank_b, bank_c, fb_out}), 15);
            if (pre == 2 && i == 0)
                check(!bank_a, "R3", "no tick on first prescaled cycle", int'(bank_a), 0);
            if (bank_a && !pa_ && bank_c && !pc_) begin
                if (seen_first && !ps_) bad_prec++;
                seen_first = 1;
            end
            if (bank_a && !pa_) ra++;
            if (bank_b && !pb_) rb++;
            if (bank_c && !pc_) rc++;
            if (bank_d && !pd_) rd++;
            if (sync_out && !ps_) rs++;
            if (fb_out && !pf_) rf++;
            if (bank_a) high_a++;
            pa_ = bank_a; pb_ = bank_b; pc_ = bank_c; pd_ = bank_d; ps_ = sync_out; pf_ = fb_out;
        end
        check(ra == 2 * rel_a(r), tag, $sformatf("code %0d bank A rises", code), ra, 2 * rel_a(r));
        check(rb == 2 * rel_b(r), tag, $sformatf("code %0d bank B rises", code), rb, 2 * rel_b(r));
        check(rc == 2 * rel_c(r), tag, $sformatf("code %0d bank C rises", code), rc, 2 * rel_c(r));
        check(high_a == 24 * pre, "R8", $sformatf("code %0d bank A high cycles", code), high_a, 24 * pre);
        check(rs == exp_sync, "R4", $sformatf("code %0d sync pulses", code), rs, exp_sync);
        check(bad_prec == 0, "R4", $sformatf("code %0d shared rise without sync", code), bad_prec, 0);
        check(rd == (dsel ? exp_sync : 2 * rel_c(r)), "R5", $sformatf("code %0d bank D rises", code),
              rd, dsel ? exp_sync : 2 * rel_c(r));
        check(rf == 48 / fb_period(fbs), "R6", $sformatf("fb_sel %0d rises", fbs), rf, 48 / fb_period(fbs));
    endtask

    // Bypass stepping: idle without edges, then exactly 48 test-clock edges (R7)
    task automatic run_bypass();
        int ra = 0, rc = 0, moved = 0;
        bit pa_ = 0, pc_ = 0;
        do_reset(1'b1, 0, 0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bank_a || bank_c || fb_out) moved++;
        end
        check(moved == 0, "R7", "outputs held without test edges", moved, 0);
        for (int e = 0; e < 48; e++) begin
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                test_clk = (j < 4);
                if (bank_a && !pa_) ra++;
                if (bank_c && !pc_) rc++;
                pa_ = bank_a; pc_ = bank_c;
            end
        end
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (bank_a && !pa_) ra++;
            if (bank_c && !pc_) rc++;
            pa_ = bank_a; pc_ = bank_c;
        end
        check(ra == 2, "R7", "bank A rises over 48 test edges", ra, 2);
        check(rc == 2, "R7", "bank C rises over 48 test edges", rc, 2);
        bypass_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int code = 0; code < 8; code++)
            run_ratio(code, code, code[0]);
        run_ratio(8 + 3, 1, 1'b1);
        run_ratio(8 + 5, 4, 1'b0);
        run_ratio(8 + 6, 6, 1'b1);
        run_bypass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule